// File: doc/BRIEF.md
# Two-Processor Channel-Flag Mailbox

This block lets two processors, numbered 0 and 1, signal each other over up to 16 channels. Messages carry no data. Each channel has one "occupied" flag per direction. The sender raises its own flag for a channel. The receiver drops the peer's flag to acknowledge the message and free the channel.

Each processor has a synchronous register port. Writes take effect at the clock edge. Read data is combinational from the address. Through its port, a processor can read both register banks plus two shared read-only words, but it can write only its own bank.

Each processor has two level interrupts:
- The receive interrupt rises when the peer has posted on a channel that this processor has not masked.
- The transmit interrupt rises when one of the processor's own unmasked channels is free.

The reset input is asserted asynchronously and released synchronously inside the block.

Top module: `chan_mbox`

## Requirements
- R1: After reset, all flags are 0 and both interrupt enables are 0. Every implemented mask bit is 1, so both interrupts of both processors are low.
- R2: A processor writing 1 to bit 16+n of its set/clear word (bank offset 0x8) makes its own flag n occupied. The flag shows in bit n of its status word (bank offset 0xC) from the cycle after the write edge. Processor 0's bank is at 0x00 and processor 1's bank is at 0x10.
- R3: A processor writing 1 to bit n of its set/clear word clears the peer's flag n. Bits written as 0 change nothing.
- R4: The set/clear word always reads as 0.
- R5: The receive interrupt of processor X is high exactly when two conditions hold:
  - bit 0 of X's control word (offset 0x0) is 1;
  - some channel n has the peer's flag n set while mask bit n (offset 0x4) is 0.
- R6: The transmit interrupt of X is high exactly when two conditions hold:
  - control bit 16 is 1;
  - some channel n has X's own flag n clear while mask bit 16+n is 0.
- R7: The control word stores only bits 0 and 16; all its other bits read 0. The mask word stores bits n and 16+n for every implemented channel n.
- R8: If one processor sets a flag in the same cycle that the other clears it, the flag ends up set.
- R9: Set/clear and mask bits for channels at or above the channel count have no effect. Those mask bits and status bits read 0.
- R10: The word at 0x3F0 holds the channel count in bits 7:0. The word at 0x3F4 holds the major revision in bits 7:4 and the minor revision in bits 3:0.
- R11: A port's writes into the other processor's bank are ignored. Reads from either port reach both banks.
- R12: Read data follows the address in the same cycle. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p0_wr | input | 1 | Processor 0 write strobe |
| p0_addr | input | 10 | Processor 0 byte address |
| p0_wdata | input | 32 | Processor 0 write data |
| p0_rdata | output | 32 | Processor 0 read data |
| p0_rx_irq | output | 1 | Processor 0 receive interrupt |
| p0_tx_irq | output | 1 | Processor 0 transmit interrupt |
| p1_wr | input | 1 | Processor 1 write strobe |
| p1_addr | input | 10 | Processor 1 byte address |
| p1_wdata | input | 32 | Processor 1 write data |
| p1_rdata | output | 32 | Processor 1 read data |
| p1_rx_irq | output | 1 | Processor 1 receive interrupt |
| p1_tx_irq | output | 1 | Processor 1 transmit interrupt |

## Verification
The bench targets six corner cases, each with a distinct failure:
- **Same-cycle set and clear.** One processor sets a channel while the other clears it. A design with clear priority loses the message.
- **Channels above the parameterised count.** A design without channel masking would raise phantom flags there, or keep mask bits there.
- **Cross-bank writes.** A processor writes into its peer's bank. A design that let the write through would corrupt the peer's control.
- **Interrupt polarities.** The receive interrupt follows the peer's set flags and the transmit interrupt follows the processor's own clear flags. A design that swapped the polarity or the flag owner would fire at the wrong times.
- **Zero bits in set/clear writes.** A zero bit must change nothing. A design that treated the word as a plain register would wipe flags.
- **Random mixed traffic.** Random writes, some from both ports in the same cycle, are compared against a bench model of flags, masks and enables.

// File: rtl/chan_mbox_pkg.sv
package chan_mbox_pkg;
  localparam int unsigned ADDR_W   = 10;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned TX_SHIFT = 16;
  localparam int unsigned MAX_CH   = 16;
  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_MASK = 4'h4;
  localparam logic [3:0] OFS_SC   = 4'h8;
  localparam logic [3:0] OFS_STAT = 4'hC;
  localparam logic [ADDR_W-1:0] CFG_ADDR = 10'h3F0;
  localparam logic [ADDR_W-1:0] VER_ADDR = 10'h3F4;
endpackage

// File: rtl/chan_mbox_rstsync.sv
module chan_mbox_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/chan_mbox_bank.sv
module chan_mbox_bank
  import chan_mbox_pkg::*;
#(
  parameter int unsigned NCH     = 16,
  parameter int unsigned BANK_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NCH-1:0]    own_flag_i,
  input  logic [NCH-1:0]    peer_flag_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [NCH-1:0]    set_o,
  output logic [NCH-1:0]    clr_o,
  output logic              rx_irq_o,
  output logic              tx_irq_o
);
  localparam int unsigned PAGE_W = ADDR_W - 4;

  logic           bank_hit, ctrl_we, mask_we, sc_we;
  logic           rxen_q, txen_q, rxen_d, txen_d;
  logic [NCH-1:0] rxmask_q, txmask_q, rxmask_d, txmask_d;

  assign bank_hit = wr_i && (addr_i[ADDR_W-1:4] == PAGE_W'(BANK_ID));
  assign ctrl_we  = bank_hit && (addr_i[3:0] == OFS_CTRL);
  assign mask_we  = bank_hit && (addr_i[3:0] == OFS_MASK);
  assign sc_we    = bank_hit && (addr_i[3:0] == OFS_SC);

  always_comb begin
    rxen_d   = wdata_i[0];
    txen_d   = wdata_i[TX_SHIFT];
    rxmask_d = wdata_i[NCH-1:0];
    txmask_d = wdata_i[TX_SHIFT +: NCH];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxen_q   <= 1'b0;
      txen_q   <= 1'b0;
      rxmask_q <= '1;
      txmask_q <= '1;
    end else begin
      if (ctrl_we) begin
        rxen_q <= rxen_d;
        txen_q <= txen_d;
      end
      if (mask_we) begin
        rxmask_q <= rxmask_d;
        txmask_q <= txmask_d;
      end
    end
  end

  assign set_o = sc_we ? wdata_i[TX_SHIFT +: NCH] : '0;
  assign clr_o = sc_we ? wdata_i[NCH-1:0] : '0;

  always_comb begin
    ctrl_o                   = '0;
    ctrl_o[0]                = rxen_q;
    ctrl_o[TX_SHIFT]         = txen_q;
    mask_o                   = '0;
    mask_o[NCH-1:0]          = rxmask_q;
    mask_o[TX_SHIFT +: NCH]  = txmask_q;
  end

  assign rx_irq_o = rxen_q && (|(peer_flag_i & ~rxmask_q));
  assign tx_irq_o = txen_q && (|(~own_flag_i & ~txmask_q));
endmodule

// File: rtl/chan_mbox_flags.sv
module chan_mbox_flags #(
  parameter int unsigned NCH = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0][NCH-1:0] set_i,
  input  logic [1:0][NCH-1:0] clr_i,
  output logic [1:0][NCH-1:0] flag_o
);
  logic [1:0][NCH-1:0] flag_q, flag_d;

  for (genvar p = 0; p < 2; p++) begin : g_dir
    always_comb begin
      flag_d[p] = set_i[p] | (flag_q[p] & ~clr_i[p]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[p] <= '0;
      end else begin
        flag_q[p] <= flag_d[p];
      end
    end

    // R8: a set request lands even when a clear arrives in the same cycle
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i[p]) |=> ((flag_q[p] & $past(set_i[p])) == $past(set_i[p])));

    // R3: a clear with no competing set drops the flag
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_i[p] & ~set_i[p])) |=> ((flag_q[p] & $past(clr_i[p] & ~set_i[p])) == '0));

    // R2: without requests the flags keep their value
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_i[p] == '0) && (clr_i[p] == '0)) |=> $stable(flag_q[p]));
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/chan_mbox_rdmux.sv
module chan_mbox_rdmux
  import chan_mbox_pkg::*;
#(
  parameter int unsigned NCH       = 16,
  parameter int unsigned VER_MAJOR = 1,
  parameter int unsigned VER_MINOR = 0
) (
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [1:0][DATA_W-1:0]     ctrl_i,
  input  logic [1:0][DATA_W-1:0]     mask_i,
  input  logic [1:0][NCH-1:0]        flag_i,
  output logic [DATA_W-1:0]          rdata_o
);
  logic bsel;

  assign bsel = addr_i[4];

  always_comb begin
    rdata_o = '0;
    if (addr_i[ADDR_W-1:5] == '0) begin
      case (addr_i[3:0])
        OFS_CTRL: rdata_o = ctrl_i[bsel];
        OFS_MASK: rdata_o = mask_i[bsel];
        OFS_STAT: rdata_o[NCH-1:0] = flag_i[bsel];
        default:  rdata_o = '0;
      endcase
    end else if (addr_i == CFG_ADDR) begin
      rdata_o[7:0] = 8'(NCH);
    end else if (addr_i == VER_ADDR) begin
      rdata_o[7:4] = 4'(VER_MAJOR);
      rdata_o[3:0] = 4'(VER_MINOR);
    end
  end
endmodule

// File: rtl/chan_mbox.sv
module chan_mbox
  import chan_mbox_pkg::*;
#(
  parameter int unsigned NCH       = 16,
  parameter int unsigned VER_MAJOR = 1,
  parameter int unsigned VER_MINOR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p0_wr,
  input  logic [ADDR_W-1:0] p0_addr,
  input  logic [DATA_W-1:0] p0_wdata,
  output logic [DATA_W-1:0] p0_rdata,
  output logic              p0_rx_irq,
  output logic              p0_tx_irq,
  input  logic              p1_wr,
  input  logic [ADDR_W-1:0] p1_addr,
  input  logic [DATA_W-1:0] p1_wdata,
  output logic [DATA_W-1:0] p1_rdata,
  output logic              p1_rx_irq,
  output logic              p1_tx_irq
);
  logic                     rst_q_n;
  logic [1:0]               wr_a, rx_a, tx_a;
  logic [1:0][ADDR_W-1:0]   addr_a;
  logic [1:0][DATA_W-1:0]   wdata_a, rdata_a, ctrl_a, mask_a;
  logic [1:0][NCH-1:0]      set_a, clr_from, clr_to, flag_a;

  chan_mbox_rstsync i_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  assign wr_a    = {p1_wr, p0_wr};
  assign addr_a  = {p1_addr, p0_addr};
  assign wdata_a = {p1_wdata, p0_wdata};
  assign clr_to  = {clr_from[0], clr_from[1]};

  for (genvar p = 0; p < 2; p++) begin : g_proc
    chan_mbox_bank #(.NCH(NCH), .BANK_ID(p)) i_bank (
      .clk         (clk),
      .rst_n       (rst_q_n),
      .wr_i        (wr_a[p]),
      .addr_i      (addr_a[p]),
      .wdata_i     (wdata_a[p]),
      .own_flag_i  (flag_a[p]),
      .peer_flag_i (flag_a[1-p]),
      .ctrl_o      (ctrl_a[p]),
      .mask_o      (mask_a[p]),
      .set_o       (set_a[p]),
      .clr_o       (clr_from[p]),
      .rx_irq_o    (rx_a[p]),
      .tx_irq_o    (tx_a[p])
    );

    chan_mbox_rdmux #(.NCH(NCH), .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR)) i_rdmux (
      .addr_i  (addr_a[p]),
      .ctrl_i  (ctrl_a),
      .mask_i  (mask_a),
      .flag_i  (flag_a),
      .rdata_o (rdata_a[p])
    );

    // R5: a receive interrupt needs at least one peer flag set
    p_rx_peer_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
      rx_a[p] |-> (flag_a[1-p] != '0));

    // R6: a transmit interrupt needs at least one own flag free
    p_tx_free_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
      tx_a[p] |-> (flag_a[p] != '1));
  end

  chan_mbox_flags #(.NCH(NCH)) i_flags (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .set_i  (set_a),
    .clr_i  (clr_to),
    .flag_o (flag_a)
  );

  assign p0_rdata  = rdata_a[0];
  assign p1_rdata  = rdata_a[1];
  assign p0_rx_irq = rx_a[0];
  assign p0_tx_irq = tx_a[0];
  assign p1_rx_irq = rx_a[1];
  assign p1_tx_irq = tx_a[1];
endmodule

// File: tb/test_chan_mbox.sv
module test_chan_mbox;
  localparam int NCH  = 12;
  localparam int VMAJ = 2;
  localparam int VMIN = 5;

  logic        clk;
  logic        rst_n;
  logic        p0_wr, p1_wr;
  logic [9:0]  p0_addr, p1_addr;
  logic [31:0] p0_wdata, p1_wdata, p0_rdata, p1_rdata;
  logic        p0_rx_irq, p0_tx_irq, p1_rx_irq, p1_tx_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [NCH-1:0] m_flag [2];
  logic [NCH-1:0] m_rxm  [2];
  logic [NCH-1:0] m_txm  [2];
  logic           m_rxen [2];
  logic           m_txen [2];

  chan_mbox #(.NCH(NCH), .VER_MAJOR(VMAJ), .VER_MINOR(VMIN)) i_chan_mbox (
    .clk(clk), .rst_n(rst_n),
    .p0_wr(p0_wr), .p0_addr(p0_addr), .p0_wdata(p0_wdata), .p0_rdata(p0_rdata),
    .p0_rx_irq(p0_rx_irq), .p0_tx_irq(p0_tx_irq),
    .p1_wr(p1_wr), .p1_addr(p1_addr), .p1_wdata(p1_wdata), .p1_rdata(p1_rdata),
    .p1_rx_irq(p1_rx_irq), .p1_tx_irq(p1_tx_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_reg(input logic [9:0] a);
    int b;
    logic [31:0] v;
    v = '0;
    b = a[4];
    if (a[9:5] == 0) begin
      case (a[3:0])
        4'h0: begin v[0] = m_rxen[b]; v[16] = m_txen[b]; end
        4'h4: begin v[NCH-1:0] = m_rxm[b]; v[16 +: NCH] = m_txm[b]; end
        4'hC: v[NCH-1:0] = m_flag[b];
        default: v = '0;
      endcase
    end else if (a == 10'h3F0) v = 32'(NCH);
    else if (a == 10'h3F4) v = 32'((VMAJ << 4) | VMIN);
    return v;
  endfunction

  function automatic logic exp_rx(input int p);
    return m_rxen[p] && (|(m_flag[1-p] & ~m_rxm[p]));
  endfunction

  function automatic logic exp_tx(input int p);
    return m_txen[p] && (|(~m_flag[p] & ~m_txm[p]));
  endfunction

  task automatic rd(input int p, input logic [9:0] a, output logic [31:0] v);
    if (p == 0) p0_addr = a; else p1_addr = a;
    #1;
    v = (p == 0) ? p0_rdata : p1_rdata;
  endtask

  task automatic wr2(input bit e0, input logic [9:0] a0, input logic [31:0] d0,
                     input bit e1, input logic [9:0] a1, input logic [31:0] d1);
    logic [NCH-1:0] s [2];
    logic [NCH-1:0] c [2];
    bit en [2];
    logic [9:0] aa [2];
    logic [31:0] dd [2];
    en[0] = e0; en[1] = e1; aa[0] = a0; aa[1] = a1; dd[0] = d0; dd[1] = d1;
    s[0] = '0; s[1] = '0; c[0] = '0; c[1] = '0;
    @(negedge clk);
    p0_wr = e0; p0_addr = a0; p0_wdata = d0;
    p1_wr = e1; p1_addr = a1; p1_wdata = d1;
    @(posedge clk);
    for (int p = 0; p < 2; p++) begin
      if (en[p] && aa[p][9:4] == 6'(p)) begin
        case (aa[p][3:0])
          4'h0: begin m_rxen[p] = dd[p][0]; m_txen[p] = dd[p][16]; end
          4'h4: begin m_rxm[p] = dd[p][NCH-1:0]; m_txm[p] = dd[p][16 +: NCH]; end
          4'h8: begin s[p] = dd[p][16 +: NCH]; c[1-p] = dd[p][NCH-1:0]; end
          default: ;
        endcase
      end
    end
    for (int p = 0; p < 2; p++) m_flag[p] = s[p] | (m_flag[p] & ~c[p]);
    #1;
    p0_wr = 1'b0; p1_wr = 1'b0;
  endtask

  task automatic wr(input int p, input logic [9:0] a, input logic [31:0] d);
    if (p == 0) wr2(1, a, d, 0, '0, '0);
    else        wr2(0, '0, '0, 1, a, d);
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v;
    logic [9:0] a;
    for (int p = 0; p < 2; p++) begin
      for (int k = 0; k < 8; k++) begin
        a = 10'(k * 4);
        rd(p, a, v);
        chk(v, exp_reg(a), $sformatf("%s port%0d addr %h", tag, p, a));
      end
    end
    chk({31'b0, p0_rx_irq}, {31'b0, exp_rx(0)}, {tag, " R5 p0 rx"});
    chk({31'b0, p1_rx_irq}, {31'b0, exp_rx(1)}, {tag, " R5 p1 rx"});
    chk({31'b0, p0_tx_irq}, {31'b0, exp_tx(0)}, {tag, " R6 p0 tx"});
    chk({31'b0, p1_tx_irq}, {31'b0, exp_tx(1)}, {tag, " R6 p1 tx"});
  endtask

  function automatic logic [9:0] pick_addr(input int p);
    int r;
    r = $urandom_range(0, 9);
    if (r < 4) return (p == 0) ? 10'h008 : 10'h018;
    if (r < 6) return (p == 0) ? 10'h004 : 10'h014;
    if (r < 8) return (p == 0) ? 10'h000 : 10'h010;
    if (r < 9) return (p == 0) ? 10'h018 : 10'h008;
    return 10'h3F0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    p0_wr = 0; p1_wr = 0; p0_addr = '0; p1_addr = '0; p0_wdata = '0; p1_wdata = '0;
    for (int p = 0; p < 2; p++) begin
      m_flag[p] = '0; m_rxm[p] = '1; m_txm[p] = '1; m_rxen[p] = 0; m_txen[p] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check_all("R1 reset");
    rd(0, 10'h004, v); chk(v, 32'h0FFF_0FFF, "R1 mask reset");

    rd(0, 10'h3F0, v); chk(v, 32'd12, "R10 config");
    rd(1, 10'h3F4, v); chk(v, 32'h25, "R10 version");
    rd(0, 10'h200, v); chk(v, 32'h0, "R12 unmapped");

    wr(0, 10'h008, 32'h0008_0000);
    rd(0, 10'h00C, v); chk(v, 32'h8, "R2 own status");
    rd(1, 10'h00C, v); chk(v, 32'h8, "R2 peer view");
    rd(0, 10'h008, v); chk(v, 32'h0, "R4 set/clear reads zero");

    wr(1, 10'h010, 32'h0000_0001);
    wr(1, 10'h014, 32'h0FFF_0FF7);
    chk({31'b0, p1_rx_irq}, 32'h1, "R5 rx on posted ch3");
    check_all("R5 directed");

    wr(1, 10'h018, 32'h0);
    rd(0, 10'h00C, v); chk(v, 32'h8, "R3 zero write no effect");
    wr(1, 10'h018, 32'h0000_0008);
    rd(0, 10'h00C, v); chk(v, 32'h0, "R3 clear by peer");
    chk({31'b0, p1_rx_irq}, 32'h0, "R5 rx drops after ack");

    wr(0, 10'h000, 32'hFFFF_FFFF);
    rd(0, 10'h000, v); chk(v, 32'h0001_0001, "R7 control bits");
    wr(0, 10'h004, 32'hFFFE_FFFF);
    chk({31'b0, p0_tx_irq}, 32'h1, "R6 tx free ch0");
    wr(0, 10'h008, 32'h0001_0000);
    chk({31'b0, p0_tx_irq}, 32'h0, "R6 tx drops when occupied");
    check_all("R6 directed");

    wr2(1, 10'h008, 32'h0020_0000, 1, 10'h018, 32'h0000_0020);
    rd(1, 10'h00C, v); chk(v & 32'h20, 32'h20, "R8 set wins");
    check_all("R8 directed");

    wr(0, 10'h008, 32'h2000_0000);
    rd(0, 10'h00C, v); chk(v, exp_reg(10'h00C), "R9 high channel set ignored");
    wr(1, 10'h014, 32'hFFFF_FFFF);
    rd(1, 10'h014, v); chk(v, 32'h0FFF_0FFF, "R9 high mask bits");

    rd(1, 10'h000, v);
    wr(0, 10'h010, 32'h0000_0000);
    rd(1, 10'h010, v); chk(v, 32'h0000_0001, "R11 cross-bank control ignored");
    wr(0, 10'h018, 32'h0000_FFFF);
    rd(1, 10'h00C, v); chk(v, exp_reg(10'h00C), "R11 cross-bank set/clear ignored");
    check_all("R11 directed");

    for (int i = 0; i < 400; i++) begin
      wr2($urandom_range(0, 1) == 1, pick_addr(0), $urandom,
          $urandom_range(0, 1) == 1, pick_addr(1), $urandom);
      check_all("random R2 R3 R7 R8 R9");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule